// File: doc/BRIEF.md
# Exception Entry and Vector Redirect Unit

This unit sits beside the commit stage of a small 32-bit in-order RISC core. When the pipeline reports a synchronous fault or trap, or when an enabled external or timer interrupt request is pending, the unit carries out the architectural entry sequence. It computes the return address to save, a faulting effective address for illegal instructions, the saved copy of the old status word, the rewritten status word, the power-control word with its low-power enables cleared, a kill of the load-linked reservation, and the handler address the program counter jumps to.

The cause is a small code. Valid codes run from 1 to 14: reset, bus error, data page fault, instruction page fault, tick timer, misalignment, illegal instruction, external interrupt, data TLB miss, instruction TLB miss, range, system call, floating point and trap. The handler address is the code shifted left by eight. An optional base register can be ORed in, and a high-memory overlay can also be ORed in. Every result is registered and is presented for exactly one cycle together with an entry strobe, so the register file can write all of them at once. A code outside the valid range produces an error pulse in place of an entry.

Top module: `exc_entry_unit`

## Requirements
- R1: On entry, `epc_out` is the faulting PC, plus 4 when the code is 0xC (system call). When `in_dslot` was set, a further 4 is subtracted, so a system call in a delay slot saves the PC unchanged.
- R2: `eear_we` pulses and `eear_out` takes the PC only when the code is 0x7 (illegal instruction). For every other cause `eear_we` stays 0 and `eear_out` keeps its value.
- R3: On entry, `esr_out` equals the `sr_in` value that was sampled for that entry.
- R4: `sr_out` on entry equals `sr_in` with these changes: bit 0 (supervisor) set; bits 1 (tick enable), 2 (interrupt enable), 3 (data MMU enable) and 4 (instruction MMU enable) cleared; bit 6 (delay-slot flag) set exactly when `in_dslot` was set. All other bits, bit 5 included, are copied. `dslot_clr` pulses when `in_dslot` was set.
- R5: `new_pc` is `code << 8`. It is ORed with `vbase_in` when `cfg_vbase_en` is 1, and ORed with 0xF0000000 when `sr_in` bit 5 (high vectors) is 1.
- R6: On entry, `pmr_out` is `pmr_in` with bit 0 (doze enable) and bit 1 (sleep enable) cleared, and `resv_kill` pulses.
- R7: An external request is taken only if `sr_in` bit 2 is set. A timer request is taken only if `sr_in` bit 1 is set. An external request is taken as code 0x8 and a timer request as code 0x5. A request that is not enabled produces no entry.
- R8: When both requests are enabled in the same cycle, the timer (code 0x5) wins.
- R9: A valid `exc_valid` wins over any interrupt request in the same cycle. The request is taken in a later cycle if it is still present.
- R10: With `exc_valid` set and a code of 0 or of 0xF and above, `unhandled_err` pulses. In that case `entry_commit`, `eear_we`, `resv_kill` and `dslot_clr` stay 0, and every data output keeps its value.
- R11: All results appear one clock after the inputs are sampled, with `entry_commit` high for that single cycle. With no cause pending, nothing is strobed and the data outputs hold.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | 5 | Exception cause code |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction was in a delay slot |
| sr_in | input | 16 | Current status word |
| pmr_in | input | 8 | Current power-control word |
| vbase_in | input | 32 | Vector base register |
| cfg_vbase_en | input | 1 | Vector base register implemented/used |
| irq_ext_req | input | 1 | External interrupt request level |
| irq_tick_req | input | 1 | Tick timer request level |
| entry_commit | output | 1 | One-cycle entry strobe |
| entry_code | output | 5 | Cause code taken |
| epc_out | output | 32 | Saved return address |
| eear_we | output | 1 | Effective address write strobe |
| eear_out | output | 32 | Effective address value |
| esr_out | output | 16 | Saved old status word |
| sr_out | output | 16 | Rewritten status word |
| pmr_out | output | 8 | Rewritten power-control word |
| resv_kill | output | 1 | Invalidate load-linked reservation |
| dslot_clr | output | 1 | Clear the pipeline delay-slot flag |
| new_pc | output | 32 | Handler address |
| unhandled_err | output | 1 | Invalid cause code pulse |

## Verification
The assertions assume that interrupt requests are levels the source holds until they are serviced, and that `exc_code` matters only while `exc_valid` is high. They also assume the inputs are steady around the sampling edge. The bench changes every input on the falling edge and holds it for a full cycle. It keeps requests asserted across the cycle where an exception wins, so the deferred interrupt can be seen taken on the next cycle. The vector overlay checks use base values whose low byte is zero, matching how handler tables are aligned.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   // status word bit positions
   localparam int SRB_SUP     = 0;
   localparam int SRB_TICK_EN = 1;
   localparam int SRB_IRQ_EN  = 2;
   localparam int SRB_DMMU_EN = 3;
   localparam int SRB_IMMU_EN = 4;
   localparam int SRB_HIVEC   = 5;
   localparam int SRB_DSLOT   = 6;
   // power-control word bit positions
   localparam int PMB_DOZE    = 0;
   localparam int PMB_SLEEP   = 1;
   // cause codes
   localparam int C_FIRST     = 1;
   localparam int C_TICK      = 5;
   localparam int C_ILLEGAL   = 7;
   localparam int C_EXTINT    = 8;
   localparam int C_SYSCALL   = 12;
   localparam int C_LAST      = 14;
   localparam int VEC_SHIFT   = 8;
   localparam int INSN_BYTES  = 4;
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
   import exc_entry_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              irq_ext_req,
   input  logic              irq_tick_req,
   input  logic              irq_en,
   input  logic              tick_en,
   output logic              take,
   output logic              bad,
   output logic [CODE_W-1:0] sel_code
);
   localparam logic [CODE_W-1:0] K_FIRST = CODE_W'(C_FIRST);
   localparam logic [CODE_W-1:0] K_LAST  = CODE_W'(C_LAST);
   localparam logic [CODE_W-1:0] K_TICK  = CODE_W'(C_TICK);
   localparam logic [CODE_W-1:0] K_EXT   = CODE_W'(C_EXTINT);

   logic code_ok, ext_ok, tick_ok;

   always_comb begin
      code_ok  = (exc_code >= K_FIRST) && (exc_code <= K_LAST);
      ext_ok   = irq_ext_req && irq_en;
      tick_ok  = irq_tick_req && tick_en;
      take     = 1'b0;
      bad      = 1'b0;
      sel_code = '0;
      if (exc_valid) begin
         sel_code = exc_code;
         take     = code_ok;
         bad      = !code_ok;
      end else if (tick_ok) begin
         sel_code = K_TICK;
         take     = 1'b1;
      end else if (ext_ok) begin
         sel_code = K_EXT;
         take     = 1'b1;
      end
   end

   // R8
   tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_valid && irq_tick_req && tick_en) |-> (take && sel_code == K_TICK));
   // R7
   gated_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_valid && !(irq_tick_req && tick_en) && !(irq_ext_req && irq_en)) |-> !take);
   // R10
   take_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && bad));
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
   import exc_entry_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              CODE_W    = 5,
   parameter bit              HAS_VBASE = 1'b1,
   parameter logic [XLEN-1:0] HIGH_OVL  = 32'hF000_0000
) (
   input  logic [CODE_W-1:0] code,
   input  logic [XLEN-1:0]   vbase,
   input  logic              vbase_en,
   input  logic              hivec,
   output logic [XLEN-1:0]   vec
);
   localparam int PAD_W = XLEN - CODE_W - VEC_SHIFT;

   logic [XLEN-1:0] base_part, raw;

   assign raw = {{PAD_W{1'b0}}, code, {VEC_SHIFT{1'b0}}};

   generate
      if (HAS_VBASE) begin : g_vbase
         assign base_part = vbase_en ? vbase : '0;
      end else begin : g_novbase
         logic unused_vb;
         assign unused_vb = ^{vbase, vbase_en};
         assign base_part = '0;
      end
   endgenerate

   assign vec = raw | base_part | (hivec ? HIGH_OVL : '0);
endmodule

// File: rtl/exc_state_upd.sv
module exc_state_upd
   import exc_entry_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 5,
   parameter int SR_W   = 16,
   parameter int PMR_W  = 8
) (
   input  logic [CODE_W-1:0] code,
   input  logic [XLEN-1:0]   pc,
   input  logic              dslot,
   input  logic [SR_W-1:0]   sr_old,
   input  logic [PMR_W-1:0]  pmr_old,
   output logic [XLEN-1:0]   epc,
   output logic              is_illegal,
   output logic [SR_W-1:0]   sr_new,
   output logic [PMR_W-1:0]  pmr_new
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   always_comb begin
      epc = pc;
      if (code == CODE_W'(C_SYSCALL)) epc = epc + STEP;
      if (dslot) epc = epc - STEP;
      is_illegal = (code == CODE_W'(C_ILLEGAL));

      sr_new = sr_old;
      sr_new[SRB_SUP]     = 1'b1;
      sr_new[SRB_TICK_EN] = 1'b0;
      sr_new[SRB_IRQ_EN]  = 1'b0;
      sr_new[SRB_DMMU_EN] = 1'b0;
      sr_new[SRB_IMMU_EN] = 1'b0;
      sr_new[SRB_DSLOT]   = dslot;

      pmr_new = pmr_old;
      pmr_new[PMB_DOZE]  = 1'b0;
      pmr_new[PMB_SLEEP] = 1'b0;
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              CODE_W    = 5,
   parameter int              SR_W      = 16,
   parameter int              PMR_W     = 8,
   parameter bit              HAS_VBASE = 1'b1,
   parameter logic [XLEN-1:0] HIGH_OVL  = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic              in_dslot,
   input  logic [SR_W-1:0]   sr_in,
   input  logic [PMR_W-1:0]  pmr_in,
   input  logic [XLEN-1:0]   vbase_in,
   input  logic              cfg_vbase_en,
   input  logic              irq_ext_req,
   input  logic              irq_tick_req,
   output logic              entry_commit,
   output logic [CODE_W-1:0] entry_code,
   output logic [XLEN-1:0]   epc_out,
   output logic              eear_we,
   output logic [XLEN-1:0]   eear_out,
   output logic [SR_W-1:0]   esr_out,
   output logic [SR_W-1:0]   sr_out,
   output logic [PMR_W-1:0]  pmr_out,
   output logic              resv_kill,
   output logic              dslot_clr,
   output logic [XLEN-1:0]   new_pc,
   output logic              unhandled_err
);
   generate
      if (CODE_W < 4) begin : g_bad_code
         $error("CODE_W too narrow for cause codes");
      end
      if (XLEN < CODE_W + VEC_SHIFT + 4) begin : g_bad_xlen
         $error("XLEN too narrow for vector layout");
      end
      if (SR_W <= SRB_DSLOT) begin : g_bad_sr
         $error("SR_W too narrow for status bits");
      end
      if (PMR_W <= PMB_SLEEP) begin : g_bad_pmr
         $error("PMR_W too narrow for power bits");
      end
   endgenerate

   logic              take, bad, illegal;
   logic [CODE_W-1:0] code;
   logic [XLEN-1:0]   epc_n, vec_n;
   logic [SR_W-1:0]   sr_n;
   logic [PMR_W-1:0]  pmr_n;

   exc_cause_arb #(.CODE_W(CODE_W)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .exc_valid    (exc_valid),
      .exc_code     (exc_code),
      .irq_ext_req  (irq_ext_req),
      .irq_tick_req (irq_tick_req),
      .irq_en       (sr_in[SRB_IRQ_EN]),
      .tick_en      (sr_in[SRB_TICK_EN]),
      .take         (take),
      .bad          (bad),
      .sel_code     (code)
   );

   exc_state_upd #(.XLEN(XLEN), .CODE_W(CODE_W), .SR_W(SR_W), .PMR_W(PMR_W)) u_upd (
      .code       (code),
      .pc         (cur_pc),
      .dslot      (in_dslot),
      .sr_old     (sr_in),
      .pmr_old    (pmr_in),
      .epc        (epc_n),
      .is_illegal (illegal),
      .sr_new     (sr_n),
      .pmr_new    (pmr_n)
   );

   exc_vec_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .HAS_VBASE(HAS_VBASE), .HIGH_OVL(HIGH_OVL)) u_vec (
      .code     (code),
      .vbase    (vbase_in),
      .vbase_en (cfg_vbase_en),
      .hivec    (sr_in[SRB_HIVEC]),
      .vec      (vec_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_commit  <= 1'b0;
         entry_code    <= '0;
         epc_out       <= '0;
         eear_we       <= 1'b0;
         eear_out      <= '0;
         esr_out       <= '0;
         sr_out        <= '0;
         pmr_out       <= '0;
         resv_kill     <= 1'b0;
         dslot_clr     <= 1'b0;
         new_pc        <= '0;
         unhandled_err <= 1'b0;
      end else begin
         entry_commit  <= take;
         eear_we       <= take && illegal;
         resv_kill     <= take;
         dslot_clr     <= take && in_dslot;
         unhandled_err <= bad;
         if (take) begin
            entry_code <= code;
            epc_out    <= epc_n;
            esr_out    <= sr_in;
            sr_out     <= sr_n;
            pmr_out    <= pmr_n;
            new_pc     <= vec_n;
            if (illegal) eear_out <= cur_pc;
         end
      end
   end

   // R3
   esr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_commit |-> esr_out == $past(sr_in));
   // R4
   sr_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_commit |-> (sr_out[SRB_SUP] && !sr_out[SRB_IRQ_EN] && !sr_out[SRB_TICK_EN]
                        && sr_out[SRB_DSLOT] == dslot_clr));
   // R6
   pmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_commit |-> (!pmr_out[PMB_DOZE] && !pmr_out[PMB_SLEEP] && resv_kill));
   // R9
   exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_commit && $past(exc_valid)) |-> entry_code == $past(exc_code));
   // R5
   plain_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_commit && !$past(cfg_vbase_en) && !$past(sr_in[SRB_HIVEC]))
      |-> new_pc == {{(XLEN-CODE_W-VEC_SHIFT){1'b0}}, entry_code, {VEC_SHIFT{1'b0}}});
   // R10
   err_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unhandled_err |-> (!entry_commit && !eear_we && !resv_kill && $stable(new_pc)
                         && $stable(sr_out) && $stable(epc_out)));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_commit |-> ($stable(new_pc) && $stable(epc_out) && !resv_kill && !dslot_clr));
   // R2
   eear_only_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eear_we |-> (entry_commit && entry_code == CODE_W'(C_ILLEGAL) && eear_out == $past(cur_pc)));
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
   typedef struct packed {
      logic        exv;
      logic [4:0]  code;
      logic [31:0] pc;
      logic        ds;
      logic [15:0] sr;
      logic [31:0] vb;
      logic        cfg;
      logic        ie;
      logic        it;
      logic        x_commit;
      logic [4:0]  x_code;
      logic [31:0] x_epc;
      logic [31:0] x_pc;
      logic        x_err;
      logic        x_eea;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      // bus error, plain                                         R1 R5
      '{1'b1, 5'h02, 32'h1000, 1'b0, 16'h0016, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h02, 32'h1000, 32'h0000_0200, 1'b0, 1'b0},
      // system call                                              R1
      '{1'b1, 5'h0C, 32'h2000, 1'b0, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h0C, 32'h2004, 32'h0000_0C00, 1'b0, 1'b0},
      // system call in delay slot                                R1
      '{1'b1, 5'h0C, 32'h2000, 1'b1, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h0C, 32'h2000, 32'h0000_0C00, 1'b0, 1'b0},
      // misalign in delay slot                                   R1 R4
      '{1'b1, 5'h06, 32'h3008, 1'b1, 16'h801F, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h06, 32'h3004, 32'h0000_0600, 1'b0, 1'b0},
      // illegal instruction                                      R2
      '{1'b1, 5'h07, 32'h4444, 1'b0, 16'h0004, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h07, 32'h4444, 32'h0000_0700, 1'b0, 1'b1},
      // data TLB miss with base                                  R5
      '{1'b1, 5'h09, 32'h5000, 1'b0, 16'h0000, 32'h00AB_C000, 1'b1, 1'b0, 1'b0, 1'b1, 5'h09, 32'h5000, 32'h00AB_C900, 1'b0, 1'b0},
      // base present but disabled                                R5
      '{1'b1, 5'h09, 32'h5000, 1'b0, 16'h0000, 32'h00AB_C000, 1'b0, 1'b0, 1'b0, 1'b1, 5'h09, 32'h5000, 32'h0000_0900, 1'b0, 1'b0},
      // trap, high vectors                                       R5
      '{1'b1, 5'h0E, 32'h6000, 1'b0, 16'h0020, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h0E, 32'h6000, 32'hF000_0E00, 1'b0, 1'b0},
      // data page fault, base plus high                          R5
      '{1'b1, 5'h03, 32'h7000, 1'b0, 16'h0021, 32'h0010_0000, 1'b1, 1'b0, 1'b0, 1'b1, 5'h03, 32'h7000, 32'hF010_0300, 1'b0, 1'b0},
      // code 0                                                   R10
      '{1'b1, 5'h00, 32'h8000, 1'b0, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h03, 32'h7000, 32'hF010_0300, 1'b1, 1'b0},
      // code 0xF                                                 R10
      '{1'b1, 5'h0F, 32'h8000, 1'b1, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h03, 32'h7000, 32'hF010_0300, 1'b1, 1'b0},
      // code 0x1F                                                R10
      '{1'b1, 5'h1F, 32'h8000, 1'b0, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h03, 32'h7000, 32'hF010_0300, 1'b1, 1'b0},
      // external irq enabled                                     R7
      '{1'b0, 5'h00, 32'h9000, 1'b0, 16'h0004, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'h08, 32'h9000, 32'h0000_0800, 1'b0, 1'b0},
      // external irq masked                                      R7
      '{1'b0, 5'h00, 32'h9100, 1'b0, 16'h0002, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5'h08, 32'h9000, 32'h0000_0800, 1'b0, 1'b0},
      // tick enabled                                             R7
      '{1'b0, 5'h00, 32'hA000, 1'b0, 16'h0002, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 5'h05, 32'hA000, 32'h0000_0500, 1'b0, 1'b0},
      // both enabled: tick wins                                  R8
      '{1'b0, 5'h00, 32'hB000, 1'b0, 16'h0006, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5'h05, 32'hB000, 32'h0000_0500, 1'b0, 1'b0},
      // both requested, only ext enabled                         R7 R8
      '{1'b0, 5'h00, 32'hB100, 1'b0, 16'h0004, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5'h08, 32'hB100, 32'h0000_0800, 1'b0, 1'b0},
      // exception beats enabled irqs                             R9
      '{1'b1, 5'h02, 32'hC000, 1'b0, 16'h0006, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5'h02, 32'hC000, 32'h0000_0200, 1'b0, 1'b0},
      // held irqs taken next                                     R9
      '{1'b0, 5'h00, 32'hC004, 1'b0, 16'h0006, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 5'h05, 32'hC004, 32'h0000_0500, 1'b0, 1'b0},
      // reset cause                                              R5
      '{1'b1, 5'h01, 32'hD000, 1'b0, 16'h0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'h01, 32'hD000, 32'h0000_0100, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [31:0] cur_pc = '0;
   logic        in_dslot = 1'b0;
   logic [15:0] sr_in = '0;
   logic [7:0]  pmr_in = 8'hFF;
   logic [31:0] vbase_in = '0;
   logic        cfg_vbase_en = 1'b0;
   logic        irq_ext_req = 1'b0;
   logic        irq_tick_req = 1'b0;
   logic        entry_commit, eear_we, resv_kill, dslot_clr, unhandled_err;
   logic [4:0]  entry_code;
   logic [31:0] epc_out, eear_out, new_pc;
   logic [15:0] esr_out, sr_out;
   logic [7:0]  pmr_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] last_eear = '0;
   logic [15:0] last_sr = '0;

   always #2.5 clk = ~clk;

   exc_entry_unit u_exc_entry_unit (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
      .cur_pc(cur_pc), .in_dslot(in_dslot), .sr_in(sr_in), .pmr_in(pmr_in),
      .vbase_in(vbase_in), .cfg_vbase_en(cfg_vbase_en),
      .irq_ext_req(irq_ext_req), .irq_tick_req(irq_tick_req),
      .entry_commit(entry_commit), .entry_code(entry_code), .epc_out(epc_out),
      .eear_we(eear_we), .eear_out(eear_out), .esr_out(esr_out), .sr_out(sr_out),
      .pmr_out(pmr_out), .resv_kill(resv_kill), .dslot_clr(dslot_clr),
      .new_pc(new_pc), .unhandled_err(unhandled_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 commit", {31'b0, entry_commit}, 32'h0);
      chk("R12 new_pc", new_pc, 32'h0);
      chk("R12 err", {31'b0, unhandled_err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         exc_valid    = TBL[i].exv;
         exc_code     = TBL[i].code;
         cur_pc       = TBL[i].pc;
         in_dslot     = TBL[i].ds;
         sr_in        = TBL[i].sr;
         vbase_in     = TBL[i].vb;
         cfg_vbase_en = TBL[i].cfg;
         irq_ext_req  = TBL[i].ie;
         irq_tick_req = TBL[i].it;
         @(negedge clk);
         // R11 strobe and code
         chk("R11 commit", {31'b0, entry_commit}, {31'b0, TBL[i].x_commit});
         chk("R9 code", {27'b0, entry_code}, {27'b0, TBL[i].x_code});
         chk("R1 epc", epc_out, TBL[i].x_epc);
         chk("R5 new_pc", new_pc, TBL[i].x_pc);
         chk("R10 err", {31'b0, unhandled_err}, {31'b0, TBL[i].x_err});
         chk("R2 eear_we", {31'b0, eear_we}, {31'b0, TBL[i].x_eea});
         chk("R2 eear", eear_out, TBL[i].x_eea ? TBL[i].pc : last_eear);
         last_eear = eear_out;
         if (TBL[i].x_commit) begin
            chk("R3 esr", {16'b0, esr_out}, {16'b0, TBL[i].sr});
            chk("R4 sr", {16'b0, sr_out},
                {16'b0, (TBL[i].sr & ~16'h005E) | 16'h0001 | (TBL[i].ds ? 16'h0040 : 16'h0)});
            chk("R4 dslot_clr", {31'b0, dslot_clr}, {31'b0, TBL[i].ds});
            chk("R6 pmr", {24'b0, pmr_out}, 32'h0000_00FC);
            chk("R6 resv", {31'b0, resv_kill}, 32'h1);
            last_sr = sr_out;
         end else begin
            chk("R10 no sr change", {16'b0, sr_out}, {16'b0, last_sr});
            chk("R10 resv quiet", {31'b0, resv_kill}, 32'h0);
            chk("R10 dslot quiet", {31'b0, dslot_clr}, 32'h0);
         end
      end
      // R11 idle: nothing pending, outputs hold
      exc_valid = 1'b0; irq_ext_req = 1'b0; irq_tick_req = 1'b0;
      @(negedge clk);
      chk("R11 idle commit", {31'b0, entry_commit}, 32'h0);
      chk("R11 idle hold", new_pc, 32'h0000_0100);
      // R12 reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 reset new_pc", new_pc, 32'h0);
      chk("R12 reset sr", {16'b0, sr_out}, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule